// File: doc/BRIEF.md
# HS200 Receive Sampling-Point Tuning Engine

This block is a hardware sequencer that picks the receive sampling tap for an eMMC link running in HS200 timing. A start request in HS200 mode walks a 6-bit tap value upward from zero. Each tap is loaded with a self-clearing update handshake. A tuning-block trial then runs on that tap, and its pass or fail result is recorded. The engine keeps the longest unbroken run of passing taps. When the sweep ends, it programs the tap that sits at the middle of that run.

The trial itself belongs to the surrounding controller. Here it appears only as a request that a later acknowledge answers, and the acknowledge carries a pass flag. A start request in any other timing mode does not sweep. It is forwarded as a one-cycle strobe to the standard tuning path. At the end of a sweep the engine pulses done and presents the chosen tap. It raises an error when no tap passed or when the final tap could not be applied.

Top module: `hs200_tap_tuner`

## Requirements
- R1: An accepted sweep loads taps 0, 1, 2 … up to SWEEP_TAPS-1 (default 39), strictly in increasing order, one load per tap. A trial is requested for a tap only after that tap's update bit has cleared, and the update bit is never high while a trial is requested.
- R2: Loading a tap raises `tap_update_o` with the new value on `tap_value_o`. The bit drops in the cycle after `tap_applied_i` is seen high. If no acknowledge arrives, the bit drops after exactly APPLY_TIMEOUT cycles (default 8) high. That tap then counts as failed, and no trial is issued for it.
- R3: A failed trial or a failed load resets the current run of passing taps to zero. A passing trial extends the run by one. The recorded best run, with its ending tap, is replaced only by a strictly longer run.
- R4: The chosen tap equals the ending tap of the best run minus the best length divided by two, rounded down. Of two runs of equal length, the one that starts earlier wins. The chosen tap is loaded as a final tap after the sweep.
- R5: When no tap passed, done is pulsed with `error_o`=1 and `chosen_tap_o`=0, and no final tap is loaded after the sweep.
- R6: `done_o` is high for exactly one cycle per sweep. `chosen_tap_o` and `error_o` change only in the cycle `done_o` is high, and they hold their values between sweeps.
- R7: A start request that arrives while a sweep is in progress has no effect. It neither restarts the sweep nor produces a forwarded strobe, and only one done pulse follows.
- R8: `mode_i` encodes the timing mode as 0 = SD, 2 = MMC SDR, 3 = MMC DDR, 4 = HS200 and 5 = HS400. A start request while idle in any mode other than 4 gives a one-cycle `std_start_o` pulse in the following cycle, with no tap load, no trial and no done.
- R9: After reset the engine is idle, with `done_o`, `error_o`, `chosen_tap_o`, `tap_update_o`, `trial_req_o` and `std_start_o` all 0.
- R10: If the final tap load times out, done is pulsed with `error_o`=1, and `chosen_tap_o` still reports the computed centre tap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Tuning start request |
| mode_i | input | 3 | Current timing mode (4 = HS200) |
| std_start_o | output | 1 | One-cycle strobe to the standard tuning path |
| tap_value_o | output | TAP_W | Tap value being loaded |
| tap_update_o | output | 1 | Self-clearing tap update request |
| tap_applied_i | input | 1 | Tap has taken effect |
| trial_req_o | output | 1 | Tuning-block trial request, held until acknowledged |
| trial_ack_i | input | 1 | Trial completed |
| trial_pass_i | input | 1 | Trial result, valid with the acknowledge |
| done_o | output | 1 | One-cycle end-of-tuning pulse |
| error_o | output | 1 | No usable tap, or final load failed |
| chosen_tap_o | output | TAP_W | Selected sampling tap |

## Verification
The forwarded strobe for a mode other than HS200 is due one cycle after the start request, and it is gone one cycle later. The update bit drops one cycle after the applied acknowledge, or after exactly APPLY_TIMEOUT high cycles. The trial request drops one cycle after the trial acknowledge. Done, the chosen tap and the error flag all appear in the same cycle, one cycle after the final load is acknowledged, or two cycles after the last trial when there is nothing to load. The bench drives inputs and samples outputs at the falling edge. It measures each update-bit high window against the delay its own responder chose, and it compares the result with a model that scans the pass pattern from each possible start.

// File: rtl/tune_pkg.sv
package tune_pkg;

  // Timing-mode code that enables the local sweep; other codes go to the standard path.
  localparam logic [2:0] MODE_HS200 = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_APPLY,
    ST_TRIAL,
    ST_NEXT,
    ST_FINAL,
    ST_FAPPLY
  } tune_state_e;

  // Middle of a passing window given its last tap and its length (floor of half).
  function automatic logic [7:0] centre_tap(input logic [7:0] last_tap,
                                            input logic [7:0] run_len);
    return last_tap - (run_len >> 1);
  endfunction

endpackage

// File: rtl/tap_apply.sv
module tap_apply #(
  parameter int TAP_W   = 6,
  parameter int TIMEOUT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic [TAP_W-1:0] val_i,
  input  logic             applied_i,
  output logic             upd_o,
  output logic [TAP_W-1:0] val_o,
  output logic             ok_o,
  output logic             fail_o
);
  localparam int CW = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(TIMEOUT - 1);

  logic          upd_q;
  logic [CW-1:0] cnt_q;
  logic [TAP_W-1:0] val_q;
  logic          expire_w;

  assign expire_w = upd_q && !applied_i && (cnt_q == CNT_LAST);
  assign ok_o     = upd_q && applied_i;
  assign fail_o   = expire_w;
  assign upd_o    = upd_q;
  assign val_o    = val_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_q <= 1'b0;
      cnt_q <= '0;
      val_q <= '0;
    end else if (go_i) begin
      upd_q <= 1'b1;
      cnt_q <= '0;
      val_q <= val_i;
    end else if (upd_q) begin
      if (applied_i || expire_w) begin
        upd_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  // R2: update window never outlives the timeout
  assert_upd_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |-> (cnt_q <= CNT_LAST));

  // R2: acknowledge clears the update bit on the next cycle
  assert_upd_self_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_q && applied_i) |=> !upd_q);

  // R2: a new load is only issued once the previous one has settled
  assert_go_when_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |-> !upd_q);

endmodule

// File: rtl/streak_track.sv
module streak_track #(
  parameter int TAP_W = 6,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             step_i,
  input  logic             pass_i,
  input  logic [TAP_W-1:0] tap_i,
  output logic [CNT_W-1:0] best_len_o,
  output logic [TAP_W-1:0] best_end_o
);
  logic [CNT_W-1:0] cur_q;
  logic [CNT_W-1:0] best_q;
  logic [TAP_W-1:0] end_q;
  logic [CNT_W-1:0] grown_w;
  logic             beats_w;

  assign grown_w    = cur_q + CNT_W'(1);
  assign beats_w    = grown_w > best_q;
  assign best_len_o = best_q;
  assign best_end_o = end_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      best_q <= '0;
      end_q  <= '0;
    end else if (clear_i) begin
      cur_q  <= '0;
      best_q <= '0;
      end_q  <= '0;
    end else if (step_i) begin
      if (pass_i) begin
        cur_q <= grown_w;
        if (beats_w) begin
          best_q <= grown_w;
          end_q  <= tap_i;
        end
      end else begin
        cur_q <= '0;
      end
    end
  end

  // R3: a failing step empties the running streak
  assert_fail_resets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !pass_i && !clear_i) |=> (cur_q == '0));

  // R3: the record only grows during a sweep
  assert_best_grows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_i |=> (best_q >= $past(best_q)));

  // R3: the record always covers the running streak
  assert_best_covers_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cur_q <= best_q);

endmodule

// File: rtl/tune_ctrl.sv
module tune_ctrl
  import tune_pkg::*;
#(
  parameter int TAP_W      = 6,
  parameter int CNT_W      = 6,
  parameter int SWEEP_TAPS = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [2:0]       mode_i,
  output logic             std_start_o,
  output logic             trial_req_o,
  input  logic             trial_ack_i,
  input  logic             trial_pass_i,
  input  logic             apply_ok_i,
  input  logic             apply_fail_i,
  input  logic             upd_i,
  output logic             go_o,
  output logic [TAP_W-1:0] go_val_o,
  output logic             clear_o,
  output logic             step_o,
  output logic             pass_o,
  output logic [TAP_W-1:0] tap_o,
  input  logic [CNT_W-1:0] best_len_i,
  input  logic [TAP_W-1:0] best_end_i,
  output logic             done_o,
  output logic             error_o,
  output logic [TAP_W-1:0] chosen_o
);
  localparam logic [TAP_W-1:0] LAST_TAP = TAP_W'(SWEEP_TAPS - 1);

  tune_state_e      state_q;
  logic [TAP_W-1:0] tap_q;
  logic             std_q, req_q, done_q, err_q;
  logic [TAP_W-1:0] chosen_q;

  logic             start_hs_w, start_std_w, have_win_w;
  logic [TAP_W-1:0] centre_w;

  assign start_hs_w  = (state_q == ST_IDLE) && start_i && (mode_i == MODE_HS200);
  assign start_std_w = (state_q == ST_IDLE) && start_i && (mode_i != MODE_HS200);
  assign have_win_w  = (best_len_i != '0);
  assign centre_w    = TAP_W'(centre_tap(8'(best_end_i), 8'(best_len_i)));

  always_comb begin
    go_o     = 1'b0;
    go_val_o = '0;
    clear_o  = 1'b0;
    step_o   = 1'b0;
    pass_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_hs_w) begin
          clear_o = 1'b1;
          go_o    = 1'b1;
        end
      end
      ST_APPLY: begin
        if (apply_fail_i) step_o = 1'b1;
      end
      ST_TRIAL: begin
        if (trial_ack_i) begin
          step_o = 1'b1;
          pass_o = trial_pass_i;
        end
      end
      ST_NEXT: begin
        if (tap_q != LAST_TAP) begin
          go_o     = 1'b1;
          go_val_o = tap_q + TAP_W'(1);
        end
      end
      ST_FINAL: begin
        if (have_win_w) begin
          go_o     = 1'b1;
          go_val_o = centre_w;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      tap_q    <= '0;
      std_q    <= 1'b0;
      req_q    <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      chosen_q <= '0;
    end else begin
      std_q  <= start_std_w;
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_hs_w) begin
            tap_q   <= '0;
            state_q <= ST_APPLY;
          end
        end
        ST_APPLY: begin
          if (apply_ok_i) begin
            req_q   <= 1'b1;
            state_q <= ST_TRIAL;
          end else if (apply_fail_i) begin
            state_q <= ST_NEXT;
          end
        end
        ST_TRIAL: begin
          if (trial_ack_i) begin
            req_q   <= 1'b0;
            state_q <= ST_NEXT;
          end
        end
        ST_NEXT: begin
          if (tap_q == LAST_TAP) begin
            state_q <= ST_FINAL;
          end else begin
            tap_q   <= tap_q + TAP_W'(1);
            state_q <= ST_APPLY;
          end
        end
        ST_FINAL: begin
          if (have_win_w) begin
            state_q <= ST_FAPPLY;
          end else begin
            done_q   <= 1'b1;
            err_q    <= 1'b1;
            chosen_q <= '0;
            state_q  <= ST_IDLE;
          end
        end
        ST_FAPPLY: begin
          if (apply_ok_i || apply_fail_i) begin
            done_q   <= 1'b1;
            err_q    <= apply_fail_i;
            chosen_q <= centre_w;
            state_q  <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign std_start_o = std_q;
  assign trial_req_o = req_q;
  assign tap_o       = tap_q;
  assign done_o      = done_q;
  assign error_o     = err_q;
  assign chosen_o    = chosen_q;

  // R1: trial and tap load never overlap
  assert_trial_after_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> !upd_i);

  // R1: sweep tap stays inside the swept range
  assert_tap_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_APPLY) |-> (tap_q <= LAST_TAP));

  // R5: an empty record leads to no final load
  assert_no_load_on_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FINAL && !have_win_w) |=> !upd_i);

  // R6: done lasts a single cycle
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R6: results move only with done
  assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> ($stable(chosen_q) && $stable(err_q)));

  // R7: no forwarded strobe while a sweep is running
  assert_busy_ignores_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> !std_q);

endmodule

// File: rtl/hs200_tap_tuner.sv
module hs200_tap_tuner #(
  parameter int TAP_W         = 6,
  parameter int SWEEP_TAPS    = 40,
  parameter int APPLY_TIMEOUT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [2:0]       mode_i,
  output logic             std_start_o,
  output logic [TAP_W-1:0] tap_value_o,
  output logic             tap_update_o,
  input  logic             tap_applied_i,
  output logic             trial_req_o,
  input  logic             trial_ack_i,
  input  logic             trial_pass_i,
  output logic             done_o,
  output logic             error_o,
  output logic [TAP_W-1:0] chosen_tap_o
);
  localparam int CNT_W = $clog2(SWEEP_TAPS + 1);

  logic             go_w, clear_w, step_w, pass_w;
  logic             ok_w, fail_w, upd_w;
  logic [TAP_W-1:0] go_val_w, tap_w, best_end_w;
  logic [CNT_W-1:0] best_len_w;

  tune_ctrl #(
    .TAP_W(TAP_W), .CNT_W(CNT_W), .SWEEP_TAPS(SWEEP_TAPS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .start_i(start_i), .mode_i(mode_i),
    .std_start_o(std_start_o),
    .trial_req_o(trial_req_o), .trial_ack_i(trial_ack_i), .trial_pass_i(trial_pass_i),
    .apply_ok_i(ok_w), .apply_fail_i(fail_w), .upd_i(upd_w),
    .go_o(go_w), .go_val_o(go_val_w),
    .clear_o(clear_w), .step_o(step_w), .pass_o(pass_w), .tap_o(tap_w),
    .best_len_i(best_len_w), .best_end_i(best_end_w),
    .done_o(done_o), .error_o(error_o), .chosen_o(chosen_tap_o)
  );

  tap_apply #(
    .TAP_W(TAP_W), .TIMEOUT(APPLY_TIMEOUT)
  ) u_apply (
    .clk(clk), .rst_n(rst_n),
    .go_i(go_w), .val_i(go_val_w), .applied_i(tap_applied_i),
    .upd_o(upd_w), .val_o(tap_value_o), .ok_o(ok_w), .fail_o(fail_w)
  );

  streak_track #(
    .TAP_W(TAP_W), .CNT_W(CNT_W)
  ) u_streak (
    .clk(clk), .rst_n(rst_n),
    .clear_i(clear_w), .step_i(step_w), .pass_i(pass_w), .tap_i(tap_w),
    .best_len_o(best_len_w), .best_end_o(best_end_w)
  );

  assign tap_update_o = upd_w;

endmodule

// File: tb/hs200_tap_tuner_bench.sv
module hs200_tap_tuner_bench;
  localparam int NT   = 40;
  localparam int TMO  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] mode = 3'd4;
  logic applied = 1'b0;
  logic trial_ack = 1'b0;
  logic trial_pass = 1'b0;
  logic std_start, upd, trial_req, done, err;
  logic [5:0] tapv, chosen;

  int checks = 0;
  int fails = 0;

  bit pass_pat [0:NT-1];
  bit tmo_pat  [0:NT-1];
  bit final_tmo = 1'b0;
  int dly_a [0:NT];
  int dly_t [0:NT];
  int seq   [0:63];
  int rec_n = 0, trials = 0, trial_on_tmo = 0, run_bad = 0;
  int done_cnt = 0, std_cnt = 0, run_len = 0, wait_a = 0, wait_t = 0;
  logic upd_prev = 1'b0, req_prev = 1'b0;

  always #5 clk = ~clk;

  hs200_tap_tuner u_hs200_tap_tuner (
    .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode),
    .std_start_o(std_start), .tap_value_o(tapv), .tap_update_o(upd),
    .tap_applied_i(applied), .trial_req_o(trial_req), .trial_ack_i(trial_ack),
    .trial_pass_i(trial_pass), .done_o(done), .error_o(err), .chosen_tap_o(chosen)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit tap_good(input int t);
    return pass_pat[t] && !tmo_pat[t];
  endfunction

  // Scan every start point; first longest window wins.
  function automatic void model(output int blen, output int centre);
    int bstart = 0;
    blen = 0;
    for (int s = 0; s < NT; s++) begin
      int r = 0;
      while ((s + r) < NT && tap_good(s + r)) r++;
      if (r > blen) begin
        blen = r;
        bstart = s;
      end
    end
    centre = (blen > 0) ? bstart + (blen - 1) / 2 : 0;
  endfunction

  // Monitor and responder, both at the falling edge.
  initial begin
    forever begin
      int cur;
      bit cur_tmo;
      @(negedge clk);
      if (upd && !upd_prev) begin
        seq[rec_n] = int'(tapv);
        rec_n++;
        run_len = 0;
        wait_a = 0;
      end
      cur = (rec_n > 0) ? rec_n - 1 : 0;
      if (cur > NT) cur = NT;
      cur_tmo = (cur < NT) ? tmo_pat[cur] : final_tmo;
      if (upd) run_len++;
      if (!upd && upd_prev) begin
        if (run_len != (cur_tmo ? TMO : dly_a[cur] + 1)) run_bad++;
      end
      if (trial_req && !req_prev) begin
        trials++;
        wait_t = 0;
        if (cur_tmo) trial_on_tmo++;
      end
      if (done) done_cnt++;
      if (std_start) std_cnt++;
      upd_prev = upd;
      req_prev = trial_req;
      if (applied) applied = 1'b0;
      else if (upd && !cur_tmo) begin
        if (wait_a == dly_a[cur]) applied = 1'b1;
        else wait_a++;
      end
      if (trial_ack) begin
        trial_ack = 1'b0;
        trial_pass = 1'b0;
      end else if (trial_req) begin
        if (wait_t == dly_t[cur]) begin
          trial_ack = 1'b1;
          trial_pass = pass_pat[cur < NT ? cur : 0];
        end else wait_t++;
      end
    end
  end

  task automatic fill(input bit p, input bit rnd);
    for (int i = 0; i < NT; i++) begin
      pass_pat[i] = rnd ? (($urandom % 3) != 0) : p;
      tmo_pat[i] = rnd ? (($urandom % 9) == 0) : 1'b0;
    end
    for (int i = 0; i <= NT; i++) begin
      dly_a[i] = rnd ? int'($urandom % 4) : 1;
      dly_t[i] = rnd ? int'($urandom % 4) : 2;
    end
    final_tmo = 1'b0;
  endtask

  task automatic run_sweep(input bit poke, input bit tmo_final_case);
    int n = 0, blen, ctr, bad = 0, good = 0, exp_err, exp_ch;
    logic [5:0] held_ch;
    logic held_err;
    rec_n = 0; trials = 0; trial_on_tmo = 0; run_bad = 0; done_cnt = 0; std_cnt = 0;
    @(negedge clk); start = 1'b1; mode = 3'd4;
    @(negedge clk); start = 1'b0;
    while (!done && n < 6000) begin
      @(negedge clk);
      n++;
      if (poke && n == 40)  begin start = 1'b1; mode = 3'd4; end
      if (poke && n == 41)  start = 1'b0;
      if (poke && n == 120) begin start = 1'b1; mode = 3'd0; end
      if (poke && n == 121) begin start = 1'b0; mode = 3'd4; end
    end
    model(blen, ctr);
    exp_err = (blen == 0 || final_tmo) ? 1 : 0;
    exp_ch = ctr;
    check(done == 1'b1, "R6 done seen", int'(done), 1);
    check(chosen == 6'(exp_ch), "R4 chosen centre tap", int'(chosen), exp_ch);
    check(err == exp_err[0], tmo_final_case ? "R10 final load error" : "R5 error flag",
          int'(err), exp_err);
    for (int i = 0; i < NT; i++) if (seq[i] != i) bad++;
    check(bad == 0, "R1 tap order", bad, 0);
    check(rec_n == (blen == 0 ? NT : NT + 1), "R5 final load count", rec_n,
          blen == 0 ? NT : NT + 1);
    if (blen > 0) check(seq[NT] == ctr, "R4 final tap loaded", seq[NT], ctr);
    for (int i = 0; i < NT; i++) if (!tmo_pat[i]) good++;
    check(trials == good, "R2 trials only on loaded taps", trials, good);
    check(trial_on_tmo == 0 && run_bad == 0, "R2 update window", run_bad + trial_on_tmo, 0);
    held_ch = chosen;
    held_err = err;
    @(negedge clk);
    check(done == 1'b0, "R6 done one cycle", int'(done), 0);
    repeat (6) @(negedge clk);
    check(chosen == held_ch && err == held_err, "R6 result held", int'(chosen), int'(held_ch));
    check(done_cnt == 1 && std_cnt == 0, "R7 single done no strobe", done_cnt * 10 + std_cnt, 10);
  endtask

  task automatic std_check(input logic [2:0] m);
    int stray = 0;
    @(negedge clk); start = 1'b1; mode = m;
    @(negedge clk); start = 1'b0;
    check(std_start == 1'b1, "R8 strobe due", int'(std_start), 1);
    @(negedge clk);
    check(std_start == 1'b0, "R8 strobe one cycle", int'(std_start), 0);
    repeat (20) begin
      @(negedge clk);
      if (upd || trial_req || done) stray++;
    end
    check(stray == 0, "R8 no sweep in other mode", stray, 0);
    mode = 3'd4;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R6 actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1977));
    fill(1'b0, 1'b0);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && !err && chosen == 6'd0 && !upd && !trial_req && !std_start,
          "R9 reset state", int'({done, err, upd, trial_req, std_start}), 0);

    fill(1'b1, 1'b0); run_sweep(1'b0, 1'b0);            // R4 all pass: centre 19
    fill(1'b0, 1'b0); run_sweep(1'b0, 1'b0);            // R5 nothing passes
    fill(1'b0, 1'b0);                                    // R4 tie: earlier window kept
    for (int i = 3; i <= 7; i++) pass_pat[i] = 1'b1;
    for (int i = 20; i <= 24; i++) pass_pat[i] = 1'b1;
    run_sweep(1'b0, 1'b0);
    fill(1'b0, 1'b0); pass_pat[39] = 1'b1; run_sweep(1'b0, 1'b0);   // R1 last tap only
    fill(1'b0, 1'b0); pass_pat[0] = 1'b1; run_sweep(1'b0, 1'b0);    // first tap only
    fill(1'b1, 1'b0); tmo_pat[10] = 1'b1; tmo_pat[11] = 1'b1;       // R3 timeout breaks run
    run_sweep(1'b0, 1'b0);
    fill(1'b1, 1'b0); final_tmo = 1'b1; run_sweep(1'b0, 1'b1);      // R10
    fill(1'b1, 1'b0); run_sweep(1'b1, 1'b0);                        // R7 busy pokes
    for (int k = 0; k < 6; k++) begin
      fill(1'b0, 1'b1);
      run_sweep(k == 2, 1'b0);
    end
    std_check(3'd0);
    std_check(3'd2);
    std_check(3'd3);
    std_check(3'd5);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule